// File: doc/BRIEF.md
# Unordered Completion Tracker

This block sits on the requesting side of a link that runs an unordered transaction mode. It keeps a table of outstanding requests, indexed by transaction tag. A read asks for a range of one to four 128-byte chunks starting at chunk 0, so one read covers at most 512 bytes. Its completions may come back one chunk at a time, in any chunk order. The tracker records which chunks have arrived and stores each chunk's data word at that chunk's own position. It reports the whole range once every requested chunk is in.

Several writes can be issued under one tag. A single completion carries a count and may acknowledge several of those writes at once. Every request, writes included, must be acknowledged before its tag is released. Reads are never held behind writes: the table imposes no order between tags, and any ordering the requester needs is its own business. Issue is only allowed while the link reports flit mode. A programmable per-tag cycle limit releases a tag that never finishes and reports an error for it.

Completions that do not fit the table are dropped and reported. These are a repeated chunk, a chunk outside the requested range, a tag with nothing outstanding, a kind mismatch or a bad count.

Top module: `uct_tracker`

## Requirements
- R1: `iss_accept_o` is combinational in the same cycle and is low whenever `flit_mode_i` is low or `iss_valid_i` is low.
- R2: A read issue is accepted only if its tag is free and `iss_len_i` is 1 to 4. The read then expects chunks 0 to `iss_len_i`-1.
- R3: Read completions are accepted for requested chunks in any order. Chunk c's word lands in bits c*DATA_W up to (c+1)*DATA_W-1 of `done_data_o`. A done pulse follows on the cycle after the completion that fills the last requested chunk, with `done_is_write_o` low.
- R4: A completion for a chunk already received raises error code 2. A completion for a chunk outside the requested range raises error code 3. In both cases the completion is dropped and the tag's state is unchanged.
- R5: A completion for a tag with nothing outstanding raises error code 1. A write completion to a read tag, or a read completion to a write tag, raises error code 4.
- R6: Write issues to a free tag, or to a tag already holding writes, are accepted up to 15 writes per tag. A read to a busy tag, or a write to a tag holding a read, is rejected.
- R7: A write completion adds `cpl_count_i` to the tag's acknowledged total. Done, with `done_is_write_o` high and zero data, follows when that total equals the number of writes issued. A count of 0, or a count that would exceed the number issued, raises error code 5 and is dropped.
- R8: A tag is released only by its finishing completion or by its timeout. A new read to that tag is rejected before release and accepted after it.
- R9: An outstanding write on one tag neither blocks issue nor delays completion of a read on another tag.
- R10: An issue is rejected when a completion for the same tag is presented in the same cycle.
- R11: With `timeout_limit_i` = L, L not 0, a tag still outstanding raises error code 6 and is released. The error appears on the (L+1)-th clock edge after the edge that accepted its first issue. A timeout is only reported in a cycle with no completion input. L = 0 disables timeouts.
- R12: After reset all tags are free and `done_valid_o` and `err_valid_o` are low.
- R13: `done_valid_o` and `err_valid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flit_mode_i | input | 1 | Link runs in flit mode; issue allowed only when high |
| timeout_limit_i | input | TMR_W | Cycle limit per tag, 0 disables |
| iss_valid_i | input | 1 | Issue request present |
| iss_is_write_i | input | 1 | Issue is a write (1) or a read (0) |
| iss_tag_i | input | TAG_W | Issue tag |
| iss_len_i | input | 3 | Read length in 128-byte chunks |
| iss_accept_o | output | 1 | Issue taken this cycle |
| cpl_valid_i | input | 1 | Completion present |
| cpl_is_write_i | input | 1 | Completion is a write acknowledgement |
| cpl_tag_i | input | TAG_W | Completion tag |
| cpl_chunk_i | input | 2 | Chunk index of a read completion |
| cpl_data_i | input | DATA_W | Read completion data word |
| cpl_count_i | input | WCNT_W | Writes acknowledged by a write completion |
| done_valid_o | output | 1 | Tag finished, one-cycle pulse |
| done_tag_o | output | TAG_W | Finished tag |
| done_is_write_o | output | 1 | Finished tag held writes |
| done_data_o | output | 4*DATA_W | Assembled read data |
| err_valid_o | output | 1 | Error pulse |
| err_code_o | output | 3 | Error code |
| err_tag_o | output | TAG_W | Tag the error refers to |

## Verification
`iss_accept_o` is a same-cycle result. It is sampled one time unit after the inputs are driven, which is before the clock edge. The done and error outputs are registered, so they are sampled at the falling edge that follows the edge which took the completion. Timeouts are due on the (L+1)-th edge after the issue edge. The bench steps one edge at a time and checks that the error is absent on every earlier step and present on exactly that one. A bench-side table of tags, chunk masks, write totals and data words predicts every result before the edge, and the bench compares at those instants.

// File: rtl/uct_pkg.sv
package uct_pkg;

    localparam int CHUNK_BYTES    = 128;
    localparam int MAX_READ_BYTES = 512;
    localparam int CHUNKS         = MAX_READ_BYTES / CHUNK_BYTES;
    localparam int CIDX_W         = $clog2(CHUNKS);
    localparam int LEN_W          = CIDX_W + 1;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_NO_TAG  = 3'd1,
        ERR_DUP     = 3'd2,
        ERR_RANGE   = 3'd3,
        ERR_KIND    = 3'd4,
        ERR_COUNT   = 3'd5,
        ERR_TIMEOUT = 3'd6
    } uct_err_e;

    // Chunks 0 .. len-1 requested.
    function automatic logic [CHUNKS-1:0] len_to_mask(input logic [LEN_W-1:0] len);
        logic [CHUNKS-1:0] m;
        for (int i = 0; i < CHUNKS; i++) begin
            m[i] = (LEN_W'(i) < len);
        end
        return m;
    endfunction

    function automatic logic [CHUNKS-1:0] chunk_bit(input logic [CIDX_W-1:0] idx);
        return CHUNKS'(1) << idx;
    endfunction

endpackage

// File: rtl/uct_tag_slot.sv
module uct_tag_slot
    import uct_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WCNT_W = 4,
    parameter int TMR_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TMR_W-1:0]         limit_i,
    input  logic                     alloc_i,
    input  logic                     alloc_write_i,
    input  logic [CHUNKS-1:0]        alloc_mask_i,
    input  logic                     cpl_hit_i,
    input  logic [CIDX_W-1:0]        cpl_chunk_i,
    input  logic [DATA_W-1:0]        cpl_data_i,
    input  logic [WCNT_W-1:0]        cpl_count_i,
    input  logic                     free_i,
    output logic                     valid_o,
    output logic                     write_o,
    output logic [CHUNKS-1:0]        need_o,
    output logic [CHUNKS-1:0]        got_o,
    output logic [WCNT_W-1:0]        issued_o,
    output logic [WCNT_W-1:0]        acked_o,
    output logic                     expired_o,
    output logic [CHUNKS*DATA_W-1:0] data_o
);

    logic              valid_q, write_q;
    logic [CHUNKS-1:0] need_q, got_q;
    logic [WCNT_W-1:0] issued_q, acked_q;
    logic [TMR_W-1:0]  timer_q;
    logic [DATA_W-1:0] data_q [CHUNKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            write_q  <= 1'b0;
            need_q   <= '0;
            got_q    <= '0;
            issued_q <= '0;
            acked_q  <= '0;
            timer_q  <= '0;
        end else if (free_i) begin
            valid_q  <= 1'b0;
            got_q    <= '0;
            issued_q <= '0;
            acked_q  <= '0;
            timer_q  <= '0;
        end else if (alloc_i && !valid_q) begin
            valid_q  <= 1'b1;
            write_q  <= alloc_write_i;
            need_q   <= alloc_write_i ? '0 : alloc_mask_i;
            got_q    <= '0;
            issued_q <= alloc_write_i ? WCNT_W'(1) : '0;
            acked_q  <= '0;
            timer_q  <= '0;
        end else begin
            if (alloc_i) begin
                issued_q <= issued_q + WCNT_W'(1);
            end
            if (cpl_hit_i) begin
                if (write_q) acked_q <= acked_q + cpl_count_i;
                else         got_q   <= got_q | chunk_bit(cpl_chunk_i);
            end
            if (valid_q && timer_q != '1) begin
                timer_q <= timer_q + TMR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (cpl_hit_i && !write_q) begin
            data_q[cpl_chunk_i] <= cpl_data_i;
        end
    end

    generate
        for (genvar c = 0; c < CHUNKS; c++) begin : g_pack
            assign data_o[c*DATA_W +: DATA_W] = data_q[c];
        end
    endgenerate

    assign valid_o   = valid_q;
    assign write_o   = write_q;
    assign need_o    = need_q;
    assign got_o     = got_q;
    assign issued_o  = issued_q;
    assign acked_o   = acked_q;
    assign expired_o = valid_q && (limit_i != '0) && (timer_q >= limit_i);

endmodule

// File: rtl/uct_cpl_judge.sv
module uct_cpl_judge
    import uct_pkg::*;
#(
    parameter int WCNT_W = 4
) (
    input  logic              cpl_valid_i,
    input  logic              cpl_write_i,
    input  logic [CIDX_W-1:0] cpl_chunk_i,
    input  logic [WCNT_W-1:0] cpl_count_i,
    input  logic              ent_valid_i,
    input  logic              ent_write_i,
    input  logic [CHUNKS-1:0] ent_need_i,
    input  logic [CHUNKS-1:0] ent_got_i,
    input  logic [WCNT_W-1:0] ent_issued_i,
    input  logic [WCNT_W-1:0] ent_acked_i,
    output logic              ok_o,
    output logic              finish_o,
    output uct_err_e          err_o
);

    logic [WCNT_W:0]     sum;
    logic [CHUNKS-1:0]   hit;

    always_comb begin
        ok_o     = 1'b0;
        finish_o = 1'b0;
        err_o    = ERR_NONE;
        sum      = {1'b0, ent_acked_i} + {1'b0, cpl_count_i};
        hit      = chunk_bit(cpl_chunk_i);
        if (cpl_valid_i) begin
            if (!ent_valid_i) begin
                err_o = ERR_NO_TAG;
            end else if (ent_write_i != cpl_write_i) begin
                err_o = ERR_KIND;
            end else if (cpl_write_i) begin
                if (cpl_count_i == '0 || sum > {1'b0, ent_issued_i}) begin
                    err_o = ERR_COUNT;
                end else begin
                    ok_o     = 1'b1;
                    finish_o = (sum == {1'b0, ent_issued_i});
                end
            end else if ((ent_need_i & hit) == '0) begin
                err_o = ERR_RANGE;
            end else if ((ent_got_i & hit) != '0) begin
                err_o = ERR_DUP;
            end else begin
                ok_o     = 1'b1;
                finish_o = ((ent_got_i | hit) == ent_need_i);
            end
        end
    end

endmodule

// File: rtl/uct_expiry_pick.sv
module uct_expiry_pick #(
    parameter int NUM_TAGS = 16,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic [NUM_TAGS-1:0] expired_i,
    output logic                any_o,
    output logic [TAG_W-1:0]    idx_o
);

    // Lowest expired tag wins.
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (expired_i[i]) begin
                any_o = 1'b1;
                idx_o = TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/uct_tracker.sv
module uct_tracker
    import uct_pkg::*;
#(
    parameter int  NUM_TAGS = 16,
    parameter int  DATA_W   = 32,
    parameter int  WCNT_W   = 4,
    parameter int  TMR_W    = 16,
    localparam int TAG_W    = $clog2(NUM_TAGS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flit_mode_i,
    input  logic [TMR_W-1:0]         timeout_limit_i,
    input  logic                     iss_valid_i,
    input  logic                     iss_is_write_i,
    input  logic [TAG_W-1:0]         iss_tag_i,
    input  logic [LEN_W-1:0]         iss_len_i,
    output logic                     iss_accept_o,
    input  logic                     cpl_valid_i,
    input  logic                     cpl_is_write_i,
    input  logic [TAG_W-1:0]         cpl_tag_i,
    input  logic [CIDX_W-1:0]        cpl_chunk_i,
    input  logic [DATA_W-1:0]        cpl_data_i,
    input  logic [WCNT_W-1:0]        cpl_count_i,
    output logic                     done_valid_o,
    output logic [TAG_W-1:0]         done_tag_o,
    output logic                     done_is_write_o,
    output logic [CHUNKS*DATA_W-1:0] done_data_o,
    output logic                     err_valid_o,
    output logic [2:0]               err_code_o,
    output logic [TAG_W-1:0]         err_tag_o
);

    logic              s_valid   [NUM_TAGS];
    logic              s_write   [NUM_TAGS];
    logic [CHUNKS-1:0] s_need    [NUM_TAGS];
    logic [CHUNKS-1:0] s_got     [NUM_TAGS];
    logic [WCNT_W-1:0] s_issued  [NUM_TAGS];
    logic [WCNT_W-1:0] s_acked   [NUM_TAGS];
    logic [CHUNKS*DATA_W-1:0] s_data [NUM_TAGS];
    logic [NUM_TAGS-1:0] s_expired;

    logic     cpl_ok, cpl_fin;
    uct_err_e cpl_err;
    logic     to_any, to_fire;
    logic [TAG_W-1:0] to_idx;

    logic iss_busy, len_ok, rd_ok, wr_ok, same_tag;
    logic [CHUNKS*DATA_W-1:0] done_data_d;

    uct_cpl_judge #(.WCNT_W(WCNT_W)) u_judge (
        .cpl_valid_i  (cpl_valid_i),
        .cpl_write_i  (cpl_is_write_i),
        .cpl_chunk_i  (cpl_chunk_i),
        .cpl_count_i  (cpl_count_i),
        .ent_valid_i  (s_valid[cpl_tag_i]),
        .ent_write_i  (s_write[cpl_tag_i]),
        .ent_need_i   (s_need[cpl_tag_i]),
        .ent_got_i    (s_got[cpl_tag_i]),
        .ent_issued_i (s_issued[cpl_tag_i]),
        .ent_acked_i  (s_acked[cpl_tag_i]),
        .ok_o         (cpl_ok),
        .finish_o     (cpl_fin),
        .err_o        (cpl_err)
    );

    uct_expiry_pick #(.NUM_TAGS(NUM_TAGS)) u_pick (
        .expired_i (s_expired),
        .any_o     (to_any),
        .idx_o     (to_idx)
    );

    assign to_fire  = to_any && !cpl_valid_i;
    assign same_tag = cpl_valid_i && (cpl_tag_i == iss_tag_i);
    assign iss_busy = s_valid[iss_tag_i];
    assign len_ok   = (iss_len_i != '0) && (iss_len_i <= LEN_W'(CHUNKS));
    assign rd_ok    = !iss_busy && len_ok;
    assign wr_ok    = !iss_busy || (s_write[iss_tag_i] && s_issued[iss_tag_i] != '1);

    assign iss_accept_o = iss_valid_i && flit_mode_i && !same_tag &&
                          !s_expired[iss_tag_i] && (iss_is_write_i ? wr_ok : rd_ok);

    generate
        for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
            uct_tag_slot #(.DATA_W(DATA_W), .WCNT_W(WCNT_W), .TMR_W(TMR_W)) u_slot (
                .clk           (clk),
                .rst           (rst),
                .limit_i       (timeout_limit_i),
                .alloc_i       (iss_accept_o && iss_tag_i == TAG_W'(t)),
                .alloc_write_i (iss_is_write_i),
                .alloc_mask_i  (len_to_mask(iss_len_i)),
                .cpl_hit_i     (cpl_ok && cpl_tag_i == TAG_W'(t)),
                .cpl_chunk_i   (cpl_chunk_i),
                .cpl_data_i    (cpl_data_i),
                .cpl_count_i   (cpl_count_i),
                .free_i        ((cpl_fin && cpl_tag_i == TAG_W'(t)) ||
                                (to_fire && to_idx == TAG_W'(t))),
                .valid_o       (s_valid[t]),
                .write_o       (s_write[t]),
                .need_o        (s_need[t]),
                .got_o         (s_got[t]),
                .issued_o      (s_issued[t]),
                .acked_o       (s_acked[t]),
                .expired_o     (s_expired[t]),
                .data_o        (s_data[t])
            );
        end

        for (genvar c = 0; c < CHUNKS; c++) begin : g_merge
            assign done_data_d[c*DATA_W +: DATA_W] =
                cpl_is_write_i ? '0 :
                (cpl_chunk_i == CIDX_W'(c)) ? cpl_data_i :
                s_data[cpl_tag_i][c*DATA_W +: DATA_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            done_valid_o    <= 1'b0;
            done_tag_o      <= '0;
            done_is_write_o <= 1'b0;
            done_data_o     <= '0;
            err_valid_o     <= 1'b0;
            err_code_o      <= ERR_NONE;
            err_tag_o       <= '0;
        end else begin
            done_valid_o <= cpl_fin;
            if (cpl_fin) begin
                done_tag_o      <= cpl_tag_i;
                done_is_write_o <= cpl_is_write_i;
                done_data_o     <= done_data_d;
            end
            err_valid_o <= (cpl_err != ERR_NONE) || to_fire;
            if (cpl_err != ERR_NONE) begin
                err_code_o <= cpl_err;
                err_tag_o  <= cpl_tag_i;
            end else if (to_fire) begin
                err_code_o <= ERR_TIMEOUT;
                err_tag_o  <= to_idx;
            end
        end
    end

endmodule

// File: rtl/uct_tracker_chk.sv
module uct_tracker_chk
    import uct_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             flit_mode_i,
    input logic             iss_valid_i,
    input logic [TAG_W-1:0] iss_tag_i,
    input logic             iss_accept_o,
    input logic             cpl_valid_i,
    input logic [TAG_W-1:0] cpl_tag_i,
    input logic             done_valid_o,
    input logic             err_valid_o,
    input logic [2:0]       err_code_o
);

    assert_accept_flit_R1: assert property (@(posedge clk) disable iff (rst)
        iss_accept_o |-> (flit_mode_i && iss_valid_i));

    assert_same_tag_block_R10: assert property (@(posedge clk) disable iff (rst)
        (iss_accept_o && cpl_valid_i) |-> (iss_tag_i != cpl_tag_i));

    assert_done_from_cpl_R3: assert property (@(posedge clk) disable iff (rst)
        done_valid_o |-> $past(cpl_valid_i));

    assert_timeout_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (err_valid_o && err_code_o == ERR_TIMEOUT) |-> !$past(cpl_valid_i));

    assert_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
        !(done_valid_o && err_valid_o));

    assert_err_coded_R4: assert property (@(posedge clk) disable iff (rst)
        err_valid_o |-> (err_code_o != ERR_NONE));

endmodule

bind uct_tracker uct_tracker_chk #(.TAG_W(TAG_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flit_mode_i  (flit_mode_i),
    .iss_valid_i  (iss_valid_i),
    .iss_tag_i    (iss_tag_i),
    .iss_accept_o (iss_accept_o),
    .cpl_valid_i  (cpl_valid_i),
    .cpl_tag_i    (cpl_tag_i),
    .done_valid_o (done_valid_o),
    .err_valid_o  (err_valid_o),
    .err_code_o   (err_code_o)
);

// File: tb/uct_tracker_bench.sv
module uct_tracker_bench;
    import uct_pkg::*;

    localparam int NT = 16;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              flit_mode_i = 1'b1;
    logic [TW-1:0]     timeout_limit_i = '0;
    logic              iss_valid_i = 1'b0, iss_is_write_i = 1'b0;
    logic [3:0]        iss_tag_i = '0;
    logic [LEN_W-1:0]  iss_len_i = '0;
    logic              iss_accept_o;
    logic              cpl_valid_i = 1'b0, cpl_is_write_i = 1'b0;
    logic [3:0]        cpl_tag_i = '0;
    logic [CIDX_W-1:0] cpl_chunk_i = '0;
    logic [DW-1:0]     cpl_data_i = '0;
    logic [CW-1:0]     cpl_count_i = '0;
    logic              done_valid_o, done_is_write_o, err_valid_o;
    logic [3:0]        done_tag_o, err_tag_o;
    logic [CHUNKS*DW-1:0] done_data_o;
    logic [2:0]        err_code_o;

    uct_tracker #(.NUM_TAGS(NT), .DATA_W(DW), .WCNT_W(CW), .TMR_W(TW)) u_uct_tracker (.*);

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Bench-side table
    bit        m_v [NT];
    bit        m_w [NT];
    bit [3:0]  m_need [NT];
    bit [3:0]  m_got [NT];
    int        m_iss [NT];
    int        m_ack [NT];
    bit [DW-1:0] m_data [NT][CHUNKS];

    bit to_exp = 0;
    int to_tag = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        iss_valid_i = 0; cpl_valid_i = 0; cpl_count_i = '0;
    endtask

    // One edge: predict, check accept, clock, check registered outputs, update table.
    task automatic step(input string req);
        bit e_acc, e_done, e_err;
        bit [2:0] e_code;
        bit [3:0] e_tag;
        bit [127:0] e_data;
        int it, ct;
        bit [3:0] hb;
        it = iss_tag_i; ct = cpl_tag_i;
        e_acc = iss_valid_i && flit_mode_i && !(cpl_valid_i && ct == it) &&
                (iss_is_write_i ? (!m_v[it] || (m_w[it] && m_iss[it] < 15))
                                : (!m_v[it] && iss_len_i >= 1 && iss_len_i <= 4));
        e_done = 0; e_err = 0; e_code = 0; e_tag = cpl_tag_i; e_data = '0;
        if (cpl_valid_i) begin
            hb = 4'(1) << cpl_chunk_i;
            if (!m_v[ct]) begin e_err = 1; e_code = 1; end
            else if (m_w[ct] != cpl_is_write_i) begin e_err = 1; e_code = 4; end
            else if (cpl_is_write_i) begin
                if (cpl_count_i == 0 || m_ack[ct] + cpl_count_i > m_iss[ct]) begin e_err = 1; e_code = 5; end
                else e_done = (m_ack[ct] + cpl_count_i == m_iss[ct]);
            end else if ((m_need[ct] & hb) == 0) begin e_err = 1; e_code = 3; end
            else if ((m_got[ct] & hb) != 0) begin e_err = 1; e_code = 2; end
            else begin
                e_done = ((m_got[ct] | hb) == m_need[ct]);
                for (int c = 0; c < CHUNKS; c++)
                    e_data[c*DW +: DW] = (c == cpl_chunk_i) ? cpl_data_i : m_data[ct][c];
            end
        end else if (to_exp) begin
            e_err = 1; e_code = 6; e_tag = 4'(to_tag);
        end
        #1;
        chk(iss_accept_o === e_acc, {req, " accept"}, 128'(iss_accept_o), 128'(e_acc));
        @(posedge clk);
        @(negedge clk);
        chk(done_valid_o === e_done, {req, " done"}, 128'(done_valid_o), 128'(e_done));
        chk(err_valid_o === e_err, {req, " err"}, 128'(err_valid_o), 128'(e_err));
        if (e_done) begin
            chk(done_tag_o === e_tag, {req, " done tag"}, 128'(done_tag_o), 128'(e_tag));
            chk(done_is_write_o === cpl_is_write_i, {req, " done kind"}, 128'(done_is_write_o), 128'(cpl_is_write_i));
            chk(done_data_o === e_data, {req, " done data"}, done_data_o, e_data);
        end
        if (e_err) begin
            chk(err_code_o === e_code, {req, " err code"}, 128'(err_code_o), 128'(e_code));
            chk(err_tag_o === e_tag, {req, " err tag"}, 128'(err_tag_o), 128'(e_tag));
        end
        // update table
        if (cpl_valid_i && !e_err) begin
            if (cpl_is_write_i) m_ack[ct] += cpl_count_i;
            else begin m_got[ct] |= (4'(1) << cpl_chunk_i); m_data[ct][cpl_chunk_i] = cpl_data_i; end
            if (e_done) m_v[ct] = 0;
        end
        if (!cpl_valid_i && to_exp) m_v[to_tag] = 0;
        if (e_acc) begin
            if (!m_v[it]) begin
                m_v[it] = 1; m_w[it] = iss_is_write_i; m_got[it] = 0; m_ack[it] = 0;
                m_need[it] = iss_is_write_i ? 4'd0 : 4'(len_to_mask(iss_len_i));
                m_iss[it] = iss_is_write_i ? 1 : 0;
            end else m_iss[it]++;
        end
        clear_in();
    endtask

    task automatic issue(input bit wr, input int tag, input int len, input string req);
        iss_valid_i = 1; iss_is_write_i = wr; iss_tag_i = 4'(tag); iss_len_i = LEN_W'(len);
        step(req);
    endtask

    task automatic rcpl(input int tag, input int chunk, input string req);
        cpl_valid_i = 1; cpl_is_write_i = 0; cpl_tag_i = 4'(tag);
        cpl_chunk_i = CIDX_W'(chunk); cpl_data_i = $urandom;
        step(req);
    endtask

    task automatic wcpl(input int tag, input int cnt, input string req);
        cpl_valid_i = 1; cpl_is_write_i = 1; cpl_tag_i = 4'(tag); cpl_count_i = CW'(cnt);
        step(req);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C71));
        for (int t = 0; t < NT; t++) begin m_v[t] = 0; m_w[t] = 0; m_iss[t] = 0; m_ack[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R12 reset state
        chk(done_valid_o === 0 && err_valid_o === 0, "R12 reset outputs", 128'({done_valid_o, err_valid_o}), 0);

        // R11 timeout with limit 5: error on 6th edge after issue edge
        timeout_limit_i = 16'd5;
        issue(0, 3, 1, "R11 issue");
        for (int k = 1; k <= 7; k++) begin
            to_exp = (k == 6); to_tag = 3;
            step("R11 wait");
        end
        to_exp = 0;
        issue(0, 3, 1, "R8 reissue after timeout");
        rcpl(3, 0, "R8 finish reissued");
        timeout_limit_i = '0;

        // R3 out-of-order chunks of a 512-byte read
        issue(0, 5, 4, "R2 full read");
        issue(0, 5, 2, "R8 busy tag read");
        rcpl(5, 3, "R3 chunk3");
        rcpl(5, 2, "R3 chunk2");
        rcpl(5, 2, "R4 dup chunk");
        rcpl(5, 0, "R3 chunk0");
        rcpl(5, 1, "R3 chunk1 last");
        // R4 range, R2 bad length
        issue(0, 6, 2, "R2 two chunks");
        rcpl(6, 3, "R4 out of range");
        issue(0, 7, 0, "R2 len zero");
        issue(0, 7, 5, "R2 len five");
        // R5
        rcpl(9, 0, "R5 unallocated");
        wcpl(6, 1, "R5 kind mismatch");
        // R6/R7 coalesced writes
        issue(1, 8, 0, "R6 write1");
        issue(1, 8, 0, "R6 write2");
        issue(1, 8, 0, "R6 write3");
        issue(0, 8, 1, "R6 read to write tag");
        issue(1, 6, 0, "R6 write to read tag");
        // R9 read on another tag completes while writes pending
        issue(0, 10, 1, "R9 read beside writes");
        rcpl(10, 0, "R9 read done first");
        wcpl(8, 4, "R7 overcount");
        wcpl(8, 0, "R7 zero count");
        wcpl(8, 2, "R7 coalesced two");
        wcpl(8, 1, "R7 last write");
        // R1 flit mode low
        flit_mode_i = 0;
        issue(0, 11, 1, "R1 flit low");
        flit_mode_i = 1;
        // R10 same-tag collision
        iss_valid_i = 1; iss_is_write_i = 0; iss_tag_i = 4'd6; iss_len_i = 3'd1;
        cpl_valid_i = 1; cpl_is_write_i = 0; cpl_tag_i = 4'd6; cpl_chunk_i = 2'd0; cpl_data_i = $urandom;
        step("R10 same tag");
        rcpl(6, 1, "R3 finish tag6");

        // random mix (R3 R4 R5 R6 R7 R8 R9 R10 R13)
        for (int n = 0; n < 3000; n++) begin
            int t;
            flit_mode_i = ($urandom_range(0, 15) != 0);
            if ($urandom_range(0, 1)) begin
                iss_valid_i = 1; iss_is_write_i = $urandom_range(0, 1);
                iss_tag_i = 4'($urandom_range(0, NT - 1)); iss_len_i = LEN_W'($urandom_range(0, 5));
            end
            if ($urandom_range(0, 2) != 0) begin
                t = $urandom_range(0, NT - 1);
                cpl_valid_i = 1; cpl_tag_i = 4'(t);
                cpl_is_write_i = (m_v[t] && $urandom_range(0, 7) != 0) ? m_w[t] : 1'($urandom_range(0, 1));
                cpl_chunk_i = CIDX_W'($urandom_range(0, 3));
                if (m_v[t] && !m_w[t] && $urandom_range(0, 3) != 0)
                    for (int c = 0; c < CHUNKS; c++)
                        if (m_need[t][c] && !m_got[t][c]) cpl_chunk_i = CIDX_W'(c);
                cpl_data_i = $urandom;
                cpl_count_i = (m_v[t] && m_w[t] && m_iss[t] > m_ack[t] && $urandom_range(0, 3) != 0)
                              ? CW'($urandom_range(1, m_iss[t] - m_ack[t])) : CW'($urandom_range(0, 15));
            end
            step("R13 random");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule